// File: doc/BRIEF.md
# Byte-Stream Packet Framer with Time-Stamp Insertion

This block sits between a codec's 8-bit byte output and the write side of a packet buffer. Each byte arrives with a valid qualifier, and a one-cycle sync strobe marks the first byte of a packet. The block packs the bytes of each packet into 32-bit quadlets and writes them to the buffer. A packet is committed only once the programmed number of valid bytes has arrived. When stamping is enabled, the cycle-timer value seen at the sync cycle is written as a leading quadlet, ahead of the payload.

A sync that arrives before the current packet is complete aborts that packet. The block tells the buffer to drop everything written since the last commit, sets a sticky input-error flag and raises a one-cycle interrupt pulse. It then starts a new packet on the byte that carried the sync. A sync without valid is a protocol violation: it is ignored and reported on a separate one-cycle pulse. The host clears the error flag by writing 1 to it.

Top module: `av_pkt_framer`

## Requirements
- R1: After reset, wr_en_o, wr_commit_o, wr_discard_o, err_o, err_irq_o and viol_o are all low.
- R2: Payload bytes are packed first byte into bits 31:24, then bits 23:16, 15:8 and 7:0. A full quadlet is written (wr_en_o high) in the cycle after its fourth byte is sampled.
- R3: The quadlet that holds the last byte of a packet is written in the cycle after that byte, with its unused low byte lanes zero. wr_commit_o is high in that same cycle.
- R4: A cycle with valid_i low neither advances the byte count nor changes the packed data.
- R5: Valid bytes that arrive outside a packet, with no sync since the last commit, produce no write.
- R6: sync_i high while valid_i is low starts nothing and writes nothing. viol_o pulses high for one cycle on the next cycle.
- R7: When ts_en_i is high at a sync, the cycle after the sync writes the quadlet {7'b0, cycle_time_i}, using the value sampled at the sync. This quadlet comes before any payload quadlet of that packet.
- R8: When ts_en_i is low at a sync, no stamp quadlet is written. The first write of the packet is payload.
- R9: A sync with valid, arriving while a packet is incomplete, raises wr_discard_o for one cycle on the next cycle. The byte carrying that sync becomes byte 0 of a new packet, and the new packet's stamp write, if any, occurs in the same cycle as the discard. The discard applies only to data written before that cycle.
- R10: Each abort sets the sticky err_o and raises err_irq_o for exactly one cycle, both on the cycle after the aborting sync.
- R11: err_clr_i high clears err_o on the next cycle. If an abort occurs in the same cycle as the clear, the set wins.
- R12: The packet length is taken from pkt_len_i at the sync and held for the whole packet. Values below 2 are treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Codec data byte |
| valid_i | input | 1 | Byte qualifier |
| sync_i | input | 1 | Start-of-packet strobe, one cycle |
| ts_en_i | input | 1 | Enable stamp quadlet |
| pkt_len_i | input | LEN_W | Packet length in bytes |
| cycle_time_i | input | TS_W | Cycle-timer value |
| err_clr_i | input | 1 | Host write-1-to-clear of error flag |
| wr_en_o | output | 1 | Buffer quadlet write strobe |
| wr_data_o | output | 32 | Buffer quadlet data |
| wr_commit_o | output | 1 | Packet complete, keep written data |
| wr_discard_o | output | 1 | Drop data written since last commit |
| err_o | output | 1 | Sticky input-error flag |
| err_irq_o | output | 1 | One-cycle pulse when the error flag is set |
| viol_o | output | 1 | Sync-without-valid pulse |

## Verification
The abort of one packet and the stamp write that opens the next packet both land in the cycle after a restarting sync. The bench provokes this by restarting a packet mid-stream with stamping enabled. It then checks three things: that the discard pulse coincides with the new stamp write, that the write order is old stamp, new stamp, new payload, and that the replacement packet commits on its own. It also lands a host clear in the same cycle as an abort and checks that the flag stays set.

// File: rtl/av_fr_pkg.sv
package av_fr_pkg;
  localparam int QUAD_W = 32;
  localparam int LANES  = QUAD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  function automatic logic [QUAD_W-1:0] put_byte(logic [QUAD_W-1:0] w,
                                                 logic [LANE_W-1:0] lane,
                                                 logic [7:0] b);
    logic [QUAD_W-1:0] r;
    r = w;
    for (int i = 0; i < LANES; i++)
      if (lane == LANE_W'(i)) r[QUAD_W-1-8*i -: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/av_fr_seq.sv
module av_fr_seq #(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sync_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  output logic             start_o,
  output logic             abort_o,
  output logic             push_o,
  output logic             last_o
);
  logic             active_q;
  logic [LEN_W-1:0] cnt_q, len_q, eff_len;

  assign eff_len = (pkt_len_i < LEN_W'(2)) ? LEN_W'(2) : pkt_len_i;
  assign start_o = valid_i & sync_i;
  assign abort_o = start_o & active_q;
  assign push_o  = valid_i & (sync_i | active_q);
  assign last_o  = valid_i & ~sync_i & active_q & ((cnt_q + LEN_W'(1)) == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= LEN_W'(2);
    end else if (start_o) begin
      active_q <= 1'b1;
      cnt_q    <= LEN_W'(1);
      len_q    <= eff_len;
    end else if (push_o) begin
      cnt_q <= cnt_q + LEN_W'(1);
      if (last_o) active_q <= 1'b0;
    end
  end

  AST_CNT_BELOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < len_q && len_q >= LEN_W'(2))); // R12
  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !start_o) |=> $stable(len_q)); // R12
endmodule

// File: rtl/av_fr_pack.sv
module av_fr_pack
  import av_fr_pkg::*;
#(
  parameter int TS_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              push_i,
  input  logic              last_i,
  input  logic [7:0]        byte_i,
  input  logic              ts_en_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              wr_en_o,
  output logic [QUAD_W-1:0] wr_data_o,
  output logic              wr_commit_o,
  output logic              wr_discard_o
);
  logic [QUAD_W-1:0] qd_q, word;
  logic [LANE_W-1:0] lane_q;

  assign word = put_byte(start_i ? '0 : qd_q, start_i ? '0 : lane_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qd_q         <= '0;
      lane_q       <= '0;
      wr_en_o      <= 1'b0;
      wr_data_o    <= '0;
      wr_commit_o  <= 1'b0;
      wr_discard_o <= 1'b0;
    end else begin
      wr_en_o      <= 1'b0;
      wr_commit_o  <= 1'b0;
      wr_discard_o <= abort_i;
      if (start_i) begin
        // length >= 2, so the opening byte never completes a quadlet
        if (ts_en_i) begin
          wr_en_o   <= 1'b1;
          wr_data_o <= {{(QUAD_W-TS_W){1'b0}}, ts_i};
        end
        qd_q   <= word;
        lane_q <= LANE_W'(1);
      end else if (push_i) begin
        if (lane_q == LANE_W'(LANES-1) || last_i) begin
          wr_en_o     <= 1'b1;
          wr_data_o   <= word;
          wr_commit_o <= last_i;
          qd_q        <= '0;
          lane_q      <= '0;
        end else begin
          qd_q   <= word;
          lane_q <= lane_q + LANE_W'(1);
        end
      end
    end
  end

  AST_COMMIT_WITH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> wr_en_o); // R3
  AST_NO_COMMIT_AND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_commit_o && wr_discard_o)); // R9
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i || push_i) |=> !wr_en_o); // R5
endmodule

// File: rtl/av_fr_err.sv
module av_fr_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      err_o <= set_i | (err_o & ~clr_i);
      irq_o <= set_i;
    end
  end

  AST_IRQ_IMPLIES_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> err_o); // R10
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> err_o); // R11
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_o); // R11
endmodule

// File: rtl/av_pkt_framer.sv
module av_pkt_framer #(
  parameter int LEN_W = 12,
  parameter int TS_W  = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  input  logic             sync_i,
  input  logic             ts_en_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [TS_W-1:0]  cycle_time_i,
  input  logic             err_clr_i,
  output logic             wr_en_o,
  output logic [31:0]      wr_data_o,
  output logic             wr_commit_o,
  output logic             wr_discard_o,
  output logic             err_o,
  output logic             err_irq_o,
  output logic             viol_o
);
  logic start, abort, push, last;

  av_fr_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sync_i(sync_i),
    .pkt_len_i(pkt_len_i), .start_o(start), .abort_o(abort),
    .push_o(push), .last_o(last)
  );

  av_fr_pack #(.TS_W(TS_W)) u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .abort_i(abort),
    .push_i(push), .last_i(last), .byte_i(byte_i), .ts_en_i(ts_en_i),
    .ts_i(cycle_time_i), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .wr_commit_o(wr_commit_o), .wr_discard_o(wr_discard_o)
  );

  av_fr_err u_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(abort), .clr_i(err_clr_i),
    .err_o(err_o), .irq_o(err_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_o <= 1'b0;
    else         viol_o <= sync_i & ~valid_i;
  end

  AST_VIOL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !valid_i) |=> viol_o); // R6
  AST_STAMP_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && valid_i && ts_en_i) |=>
      (wr_en_o && wr_data_o == {{(32-TS_W){1'b0}}, $past(cycle_time_i)})); // R7
  AST_DROP_NEEDS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_discard_o |-> $past(sync_i && valid_i)); // R9
  AST_ERR_RISE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(err_o)) |-> err_irq_o); // R10
endmodule

// File: tb/sim_av_pkt_framer.sv
`timescale 1ns/1ps
module sim_av_pkt_framer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  byte_d = 0;
  logic        valid = 0, sync = 0, ts_en = 0, clr = 0;
  logic [11:0] plen = 12'd4;
  logic [24:0] ct = '0;
  logic        wr_en, commit, discard, err, irq, viol;
  logic [31:0] wr_data;

  int total = 0, bad = 0;
  logic [31:0] wq [32];
  int wn, n_commit, n_disc, n_disc_wr, n_irq, n_viol;

  always #5 clk = ~clk;

  av_pkt_framer u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_d), .valid_i(valid),
    .sync_i(sync), .ts_en_i(ts_en), .pkt_len_i(plen), .cycle_time_i(ct),
    .err_clr_i(clr), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .wr_commit_o(commit), .wr_discard_o(discard), .err_o(err),
    .err_irq_o(irq), .viol_o(viol)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    wn = 0; n_commit = 0; n_disc = 0; n_disc_wr = 0; n_irq = 0; n_viol = 0;
  endtask

  task automatic step(logic v, logic s, logic [7:0] b, logic c = 1'b0);
    @(negedge clk);
    valid = v; sync = s; byte_d = b; clr = c;
    @(posedge clk);
    #1;
    if (wr_en && wn < 32) begin wq[wn] = wr_data; wn++; end
    if (commit) n_commit++;
    if (discard) n_disc++;
    if (discard && wr_en) n_disc_wr++;
    if (irq) n_irq++;
    if (viol) n_viol++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 wr_en", wr_en, 0);
    chk("R1 commit", commit, 0);
    chk("R1 discard", discard, 0);
    chk("R1 err", err, 0);
    chk("R1 irq/viol", {irq, viol}, 0);
  endtask

  task automatic t_basic();
    clr_log(); ts_en = 0; plen = 12'd6;
    step(1, 1, 8'h11);
    for (int i = 2; i <= 6; i++) step(1, 0, 8'h10 + 8'(i));
    idle(2);
    chk("R8 writes", wn, 2);
    chk("R2 quad0", wq[0], 32'h11121314);
    chk("R3 tail", wq[1], 32'h15160000);
    chk("R3 commit", n_commit, 1);
  endtask

  task automatic t_stamp();
    clr_log(); ts_en = 1; plen = 12'd5; ct = 25'h1ABCDEF;
    step(1, 1, 8'hA0);
    ct = 25'h0000055;
    for (int i = 1; i < 5; i++) step(1, 0, 8'hA0 + 8'(i));
    idle(2);
    chk("R7 writes", wn, 3);
    chk("R7 stamp", wq[0], 32'h01ABCDEF);
    chk("R7 payload", wq[1], 32'hA0A1A2A3);
    chk("R3 tail", wq[2], 32'hA4000000);
  endtask

  task automatic t_gaps();
    clr_log(); ts_en = 0; plen = 12'd4;
    step(1, 1, 8'h21); step(0, 0, 8'hEE); step(1, 0, 8'h22);
    step(0, 0, 8'hEE); step(0, 0, 8'hEE); step(1, 0, 8'h23);
    chk("R4 no early write", wn, 0);
    step(1, 0, 8'h24); idle(1);
    chk("R4 quad", wq[0], 32'h21222324);
    chk("R4 commit", n_commit, 1);
  endtask

  task automatic t_stray();
    clr_log(); ts_en = 1;
    for (int i = 0; i < 6; i++) step(1, 0, 8'h30 + 8'(i));
    idle(1);
    chk("R5 no writes", wn, 0);
  endtask

  task automatic t_viol();
    clr_log(); ts_en = 1;
    step(0, 1, 8'h40);
    chk("R6 pulse", viol, 1);
    step(1, 0, 8'h41); step(1, 0, 8'h42); idle(1);
    chk("R6 one pulse", n_viol, 1);
    chk("R6 no start", wn, 0);
  endtask

  task automatic t_restart();
    clr_log(); ts_en = 1; plen = 12'd8; ct = 25'h0000AAA;
    step(1, 1, 8'hC0); step(1, 0, 8'hC1); step(1, 0, 8'hC2);
    ct = 25'h0000BBB; plen = 12'd4;
    step(1, 1, 8'hD0);
    chk("R10 err set", err, 1);
    chk("R10 irq", irq, 1);
    step(1, 0, 8'hD1); step(1, 0, 8'hD2); step(1, 0, 8'hD3); idle(2);
    chk("R9 discard", n_disc, 1);
    chk("R9 drop with stamp", n_disc_wr, 1);
    chk("R9 writes", wn, 3);
    chk("R9 old stamp", wq[0], 32'h00000AAA);
    chk("R9 new stamp", wq[1], 32'h00000BBB);
    chk("R9 new payload", wq[2], 32'hD0D1D2D3);
    chk("R9 commit", n_commit, 1);
    chk("R10 irq once", n_irq, 1);
    chk("R10 sticky", err, 1);
  endtask

  task automatic t_clear();
    clr_log(); ts_en = 0; plen = 12'd8;
    step(0, 0, 8'h00, 1'b1);
    chk("R11 cleared", err, 0);
    step(1, 1, 8'hE0); step(1, 0, 8'hE1);
    step(1, 1, 8'hF0, 1'b1);
    chk("R11 set wins", err, 1);
    idle(1);
    chk("R11 irq once", n_irq, 1);
    for (int i = 1; i < 8; i++) step(1, 0, 8'hF0 + 8'(i));
    idle(1);
    chk("R11 clear again", 32'(err), 1);
    step(0, 0, 8'h00, 1'b1);
    chk("R11 cleared 2", err, 0);
  endtask

  task automatic t_len();
    clr_log(); ts_en = 0; plen = 12'd1;
    step(1, 1, 8'h51); step(1, 0, 8'h52); idle(1);
    chk("R12 clamp quad", wq[0], 32'h51520000);
    chk("R12 clamp commit", n_commit, 1);
    clr_log(); plen = 12'd3;
    step(1, 1, 8'h61);
    plen = 12'd8;
    step(1, 0, 8'h62); step(1, 0, 8'h63); idle(1);
    chk("R12 latched", wq[0], 32'h61626300);
    chk("R12 latched commit", n_commit, 1);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr_log();
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    idle(2);
    t_basic();
    t_stamp();
    t_gaps();
    t_stray();
    t_viol();
    t_restart();
    t_clear();
    t_len();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule